// File: doc/BRIEF.md
# Edge-Triggered Interrupt Message Controller

This block gathers eleven level-sensitive interrupt lines and turns each fresh assertion into a record of activity and, if that source is enabled, into a single posted memory-write message. The message is sent on a valid/ready output channel. A source that goes high while its level bit is clear sets its bit in both the latched-level register and the sticky pending register. When the input falls, only the level bit clears. The pending register empties whenever software touches it, by a read or by a write.

Each source has a steering bit. The bit picks one of two message-address registers. The chosen register supplies the whole message: its upper bits, with the low five cleared, form the target address, and its low five bits form the write data. Two request views give the level ANDed with the mask, split by the steering bit. Sources that assert together are turned into messages one at a time, lowest bit first. A short queue in front of the output absorbs backpressure, and sources still waiting for a queue slot stay marked until they get one.

Source lines 0 to 5 are normally the bus interrupt lines A to F, line 6 an external bus interrupt, line 7 a bus error, line 8 the keyboard/mouse port, line 9 is spare and line 10 the serial port. Software uses a 32-bit register port with an address, read and write strobes, write data and combinational read data.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset both message-address registers read the parameter MSG_ADDR_RST. Mask, steering, pending, level and both request views read zero, and msg_valid is low.
- R2: A source rising while its level bit is clear sets that bit in level (offset 0x028) and pending (0x01C). Falling clears the level bit only.
- R3: Writes to level (0x028), request view 0 (0x00C) and request view 1 (0x014) have no effect. Reading level does not change it.
- R4: A read of pending returns its value, and the register is zero afterwards. A write to pending clears it whatever the data.
- R5: A rising edge on a source whose mask bit (0x018) is set produces exactly one message. A masked source produces none.
- R6: The message uses address register 1 (0x010) if the source's steering bit (0x024) is 1, and address register 0 (0x004) otherwise. msg_addr is that register with bits [4:0] zero, and msg_data is its bits [4:0], zero-extended.
- R7: Request view 0 reads level & mask & ~steer. Request view 1 reads level & mask & steer.
- R8: Sources rising in the same cycle produce messages in ascending bit order.
- R9: While msg_valid is high and msg_ready low, msg_valid, msg_addr and msg_data hold steady. No message is lost however long the stall lasts.
- R10: Address registers read back all 32 written bits. Mask and steering read back bits [10:0] and read zero above.
- R11: A source held high produces no further pending bit or message after its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt inputs |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Sink accepts message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The hardest case to reach from the ports is more simultaneous enabled edges than the queue can hold, while the sink is stalled. In that case some sources must wait in the arbiter's request vector, and their order must still come out intact. The stimulus programs a steering pattern that makes each message identify its source class. It raises six enabled sources in one cycle with msg_ready low and keeps the stall on for many cycles. Then it drains the queue and compares the address sequence against the ascending-bit order.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int REG_W = 32;
  localparam int LOW_W = 5;

  localparam logic [11:0] OFS_MADDR0 = 12'h004;
  localparam logic [11:0] OFS_VIEW0  = 12'h00C;
  localparam logic [11:0] OFS_MADDR1 = 12'h010;
  localparam logic [11:0] OFS_VIEW1  = 12'h014;
  localparam logic [11:0] OFS_MASK   = 12'h018;
  localparam logic [11:0] OFS_PEND   = 12'h01C;
  localparam logic [11:0] OFS_STEER  = 12'h024;
  localparam logic [11:0] OFS_LEVEL  = 12'h028;

  // Target address: register with its low field forced to zero
  function automatic logic [REG_W-1:0] msg_addr_of(input logic [REG_W-1:0] r);
    msg_addr_of = {r[REG_W-1:LOW_W], {LOW_W{1'b0}}};
  endfunction

  // Payload: the low field of the same register
  function automatic logic [REG_W-1:0] msg_data_of(input logic [REG_W-1:0] r);
    msg_data_of = {{(REG_W-LOW_W){1'b0}}, r[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               pend_clr,
  output logic [NUM_SRC-1:0] level_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] rise
);
  assign rise = src_lvl & ~level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      pend_q  <= '0;
    end else begin
      level_q <= src_lvl;
      pend_q  <= (pend_clr ? '0 : pend_q) | rise;
    end
  end

  // R2: a detected edge always lands in pending, even against a clear
  assert_edge_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R4: a clear with no new edge empties pending
  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && rise == '0) |=> (pend_q == '0));

  // R11: pending only grows where an edge was seen
  assert_pend_grow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_msg_arbiter.sv
module irq_msg_arbiter
  import irq_msg_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] new_req,
  input  logic [NUM_SRC-1:0] steer,
  input  logic [REG_W-1:0]   maddr0,
  input  logic [REG_W-1:0]   maddr1,
  input  logic               slot_free,
  output logic               push,
  output logic [REG_W-1:0]   push_addr,
  output logic [REG_W-1:0]   push_data,
  output logic [NUM_SRC-1:0] grant
);
  logic [NUM_SRC-1:0] req_q;
  logic               use_one;
  logic [REG_W-1:0]   chosen;

  // lowest set bit wins
  assign grant     = slot_free ? (req_q & (~req_q + 1'b1)) : '0;
  assign push      = (grant != '0);
  assign use_one   = |(grant & steer);
  assign chosen    = use_one ? maddr1 : maddr0;
  assign push_addr = msg_addr_of(chosen);
  assign push_data = msg_data_of(chosen);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= (req_q & ~grant) | new_req;
  end

  // R8: one source per message
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8: no waiting source below the granted one
  assert_grant_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (((grant - 1'b1) & req_q) == '0));

  // R9: a waiting source is never dropped
  assert_req_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_free && req_q != '0) |=> ((req_q & $past(req_q)) == $past(req_q)));
endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_dat,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_dat;
  end

  // R9: queue is never written past capacity nor read when empty
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int          NUM_SRC      = 11,
  parameter int          ADDR_W       = 12,
  parameter int          QDEPTH       = 4,
  parameter logic [31:0] MSG_ADDR_RST = 32'hF000_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int ENT_W = 2 * REG_W;

  logic [REG_W-1:0]   maddr0_q, maddr1_q;
  logic [NUM_SRC-1:0] mask_q, steer_q;
  logic [NUM_SRC-1:0] level_q, pend_q, rise, grant;
  logic               pend_clr, push, q_full, q_empty, pop;
  logic [REG_W-1:0]   push_addr, push_data;
  logic [ENT_W-1:0]   head;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    hit = (a == ADDR_W'(ofs));
  endfunction

  assign pend_clr = (reg_rd || reg_wr) && hit(reg_addr, OFS_PEND);

  irq_edge_latch #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .pend_clr(pend_clr),
    .level_q(level_q), .pend_q(pend_q), .rise(rise)
  );

  irq_msg_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .new_req(rise & mask_q), .steer(steer_q),
    .maddr0(maddr0_q), .maddr1(maddr1_q), .slot_free(!q_full),
    .push(push), .push_addr(push_addr), .push_data(push_data), .grant(grant)
  );

  assign pop = msg_valid && msg_ready;

  irq_msg_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_dat({push_addr, push_data}),
    .pop(pop), .head(head), .full(q_full), .empty(q_empty)
  );

  assign msg_valid = !q_empty;
  assign msg_addr  = head[ENT_W-1:REG_W];
  assign msg_data  = head[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maddr0_q <= MSG_ADDR_RST;
      maddr1_q <= MSG_ADDR_RST;
      mask_q   <= '0;
      steer_q  <= '0;
    end else if (reg_wr) begin
      if (hit(reg_addr, OFS_MADDR0)) maddr0_q <= reg_wdata;
      if (hit(reg_addr, OFS_MADDR1)) maddr1_q <= reg_wdata;
      if (hit(reg_addr, OFS_MASK))   mask_q   <= reg_wdata[NUM_SRC-1:0];
      if (hit(reg_addr, OFS_STEER))  steer_q  <= reg_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit(reg_addr, OFS_MADDR0)) reg_rdata = maddr0_q;
      if (hit(reg_addr, OFS_MADDR1)) reg_rdata = maddr1_q;
      if (hit(reg_addr, OFS_MASK))   reg_rdata = REG_W'(mask_q);
      if (hit(reg_addr, OFS_STEER))  reg_rdata = REG_W'(steer_q);
      if (hit(reg_addr, OFS_PEND))   reg_rdata = REG_W'(pend_q);
      if (hit(reg_addr, OFS_LEVEL))  reg_rdata = REG_W'(level_q);
      if (hit(reg_addr, OFS_VIEW0))  reg_rdata = REG_W'(level_q & mask_q & ~steer_q);
      if (hit(reg_addr, OFS_VIEW1))  reg_rdata = REG_W'(level_q & mask_q & steer_q);
    end
  end

  // R9: a stalled message holds still
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R6: every message carries an address with a clear low field
  assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[LOW_W-1:0] == '0));

  // R5: only masked-in sources are granted
  assert_grant_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((grant & ~mask_q & ~$past(mask_q)) == '0));
endmodule

// File: tb/irq_msg_ctrl_bench.sv
module irq_msg_ctrl_bench;
  localparam int          NS     = 11;
  localparam logic [31:0] RST_MA = 32'hF000_0003;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src_lvl = '0;
  logic [11:0] reg_addr = '0;
  logic reg_rd = 0, reg_wr = 0, msg_ready = 1;
  logic [31:0] reg_wdata = '0, reg_rdata, msg_addr, msg_data;
  logic msg_valid;

  int checks = 0, errors = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  int log_n = 0;

  always #4 clk = ~clk;

  irq_msg_ctrl #(.MSG_ADDR_RST(RST_MA)) u_irq_msg_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready && log_n < 64) begin
      log_a[log_n] = msg_addr;
      log_d[log_n] = msg_data;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic drive(input logic [NS-1:0] v);
    @(negedge clk); src_lvl = v;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] ea(input logic [31:0] r); return r & 32'hFFFF_FFE0; endfunction
  function automatic logic [31:0] ed(input logic [31:0] r); return r % 32; endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 msg_valid", {31'b0, msg_valid}, 0);
    rd(12'h004, v); chk("R1 maddr0", v, RST_MA);
    rd(12'h010, v); chk("R1 maddr1", v, RST_MA);
    rd(12'h018, v); chk("R1 mask", v, 0);
    rd(12'h024, v); chk("R1 steer", v, 0);
    rd(12'h01C, v); chk("R1 pend", v, 0);
    rd(12'h028, v); chk("R1 level", v, 0);
    rd(12'h00C, v); chk("R1 view0", v, 0);
    rd(12'h014, v); chk("R1 view1", v, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(12'h004, 32'h1234_5667); rd(12'h004, v); chk("R10 maddr0", v, 32'h1234_5667);
    wr(12'h010, 32'hABCD_E01F); rd(12'h010, v); chk("R10 maddr1", v, 32'hABCD_E01F);
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, v); chk("R10 mask", v, 32'h7FF);
    wr(12'h024, 32'hFFFF_F800); rd(12'h024, v); chk("R10 steer", v, 0);
    wr(12'h018, 0);
  endtask

  task automatic t_edge_masked;
    logic [31:0] v;
    log_n = 0;
    drive(11'h008);
    rd(12'h028, v); chk("R2 level set", v, 32'h008);
    rd(12'h01C, v); chk("R2 pend set", v, 32'h008);
    rd(12'h01C, v); chk("R4 pend read clears", v, 0);
    chk("R5 masked no msg", log_n, 0);
    wr(12'h028, 0); wr(12'h00C, 32'hFFFF); wr(12'h014, 32'hFFFF);
    rd(12'h028, v); chk("R3 level after write", v, 32'h008);
    rd(12'h028, v); chk("R3 level after read", v, 32'h008);
    drive(11'h000);
    rd(12'h028, v); chk("R2 level cleared", v, 0);
    rd(12'h01C, v); chk("R2 fall leaves pend", v, 0);
    drive(11'h002); drive(11'h000);
    rd(12'h028, v); chk("R2 fall clears only level", v, 0);
    wr(12'h01C, 32'h0000_0000);
    rd(12'h01C, v); chk("R4 pend write clears", v, 0);
  endtask

  task automatic t_msg_single;
    log_n = 0;
    wr(12'h018, 32'h010); wr(12'h024, 0);
    drive(11'h010);
    chk("R5 one msg", log_n, 1);
    chk("R6 addr from maddr0", log_a[0], ea(32'h1234_5667));
    chk("R6 data from maddr0", log_d[0], ed(32'h1234_5667));
    drive(11'h000);
    wr(12'h024, 32'h010);
    drive(11'h010);
    chk("R5 second msg", log_n, 2);
    chk("R6 addr from maddr1", log_a[1], ea(32'hABCD_E01F));
    chk("R6 data from maddr1", log_d[1], ed(32'hABCD_E01F));
    repeat (20) @(negedge clk);
    chk("R11 held source silent", log_n, 2);
    wr(12'h01C, 0); repeat (5) @(negedge clk);
    begin logic [31:0] v; rd(12'h01C, v); chk("R11 held no new pend", v, 0); end
    drive(11'h000);
  endtask

  task automatic t_views;
    logic [31:0] v;
    wr(12'h018, 32'h0F0); wr(12'h024, 32'h0A0);
    drive(11'h1F0);
    rd(12'h00C, v); chk("R7 view0", v, 32'h050);
    rd(12'h014, v); chk("R7 view1", v, 32'h0A0);
    drive(11'h000);
    rd(12'h00C, v); chk("R7 view0 idle", v, 0);
  endtask

  task automatic t_order;
    logic [31:0] exp_a [6];
    logic [31:0] a1, a0;
    a1 = ea(32'hABCD_E01F); a0 = ea(32'h1234_5667);
    // bits 0,2,4,7,9,10 with bits 0,2,7 steered to address 1
    exp_a[0] = a1; exp_a[1] = a1; exp_a[2] = a0;
    exp_a[3] = a1; exp_a[4] = a0; exp_a[5] = a0;
    wr(12'h018, 32'h7FF); wr(12'h024, 32'h085);
    log_n = 0;
    @(negedge clk); msg_ready = 0;
    drive(11'h695);
    begin
      logic [31:0] hold_a;
      hold_a = msg_addr;
      chk("R9 valid under stall", {31'b0, msg_valid}, 1);
      repeat (30) @(negedge clk);
      chk("R9 addr stable", msg_addr, hold_a);
      chk("R9 none taken", log_n, 0);
    end
    @(negedge clk); msg_ready = 1;
    repeat (15) @(negedge clk);
    chk("R9 all delivered", log_n, 6);
    for (int i = 0; i < 6; i++) chk("R8 order", log_a[i], exp_a[i]);
    drive(11'h000);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_edge_masked;
    t_msg_single;
    t_views;
    t_order;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule